// File: doc/BRIEF.md
# Boot Bus Region Timing Sequencer

This block drives the chip-enable, output-enable and write-enable strobes of one chip-select region on an asynchronous external boot bus. The region is meant for a CompactFlash card accessed in PIO mode. A host issues one read or one write at a time with a request pulse, an address, a direction and write data. The block then steps through a fixed order of phases: CE setup, strobe active, hold with CE still low, and pause with CE high. It captures read data at the clock edge that ends the read strobe, and it signals completion with a one-clock acknowledge.

The length of every phase comes from configuration inputs counted in timing ticks. A two-bit multiplier code sets how many base clocks make one tick. The active, hold and pause fields are stored as the tick count minus one. The setup field is a plain tick count and may be zero. An optional wait mode keeps the strobe active for as long as the device holds IORDY low.

Top module: `bbus_region_seq`

## Requirements
- R1: The multiplier code sets the base clocks per tick: code 3 gives 8, code 0 gives 4, code 2 gives 2 and code 1 gives 1. Every phase length is scaled by this factor.
- R2: An accepted access drives CE low first. With a setup field of S, the strobe falls S ticks later; with S of 0 the strobe falls on the same clock edge as CE.
- R3: The strobe stays low for N+1 ticks, where N is the output-enable field for a read and the write-enable field for a write.
- R4: After the strobe rises, CE stays low for H+1 ticks and then rises. H is the read-hold field for a read and the write-hold field for a write.
- R5: After CE rises, a pause of P+1 ticks follows, where P is the pause field. The acknowledge output is then high for exactly one clock.
- R6: Read data is captured from the bus at the clock edge where OE rises. The captured value is held on the read data output until the next read.
- R7: When the wait-mode input is 1, the strobe does not end while IORDY is low; it ends at the first clock after the tick count has run out on which IORDY is high. When wait mode is 0, IORDY has no effect.
- R8: A request while the region enable input is 0 is ignored: CE, OE and WE stay high and no acknowledge is given.
- R9: A request that arrives during an access in progress is ignored. The running access keeps its timing and address, only one acknowledge is given, and no second access follows.
- R10: OE and WE are never low at the same time, and a strobe is low only while CE is low. A write never drives OE low. During a write strobe the bus carries the request's write data, and the address is stable while CE is low.
- R11: Out of reset, CE, OE and WE are high and the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request pulse |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| region_en_i | input | 1 | Region enable |
| mult_code_i | input | 2 | Tick multiplier code |
| wait_mode_i | input | 1 | IORDY stretch enable |
| setup_i | input | CNT_W | CE-to-strobe ticks |
| oe_len_i | input | CNT_W | Read strobe ticks minus one |
| we_len_i | input | CNT_W | Write strobe ticks minus one |
| rd_hold_i | input | CNT_W | Read hold ticks minus one |
| wr_hold_i | input | CNT_W | Write hold ticks minus one |
| pause_i | input | CNT_W | Pause ticks minus one |
| bus_ce_n_o | output | 1 | Chip enable, active low |
| bus_oe_n_o | output | 1 | Output enable, active low |
| bus_we_n_o | output | 1 | Write enable, active low |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data |
| bus_iordy_i | input | 1 | Device ready |

## Verification
Any error in the phase counter or the tick prescaler shows up in the very access where it happens. The number of clocks that CE, OE or WE spend low, or the number of clocks between CE rising and the acknowledge, then differs from the configured value by at least one base clock. A wrong capture point shows at once on the read data output, because the bench changes the bus data on every strobe clock. An access that should have been ignored leaves a CE pulse or an extra acknowledge within a few clocks.

// File: rtl/bbus_pkg.sv
package bbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_PAUSE
  } phase_e;

  localparam int PRE_W = 3;

  // base clocks per tick minus one: code 3 -> 8, 0 -> 4, 2 -> 2, 1 -> 1
  function automatic logic [PRE_W-1:0] clocks_m1(input logic [1:0] code);
    case (code)
      2'd3:    clocks_m1 = 3'd7;
      2'd0:    clocks_m1 = 3'd3;
      2'd2:    clocks_m1 = 3'd1;
      default: clocks_m1 = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bbus_tick_div.sv
module bbus_tick_div
  import bbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mult_code_i,
  input  logic       restart_i,
  input  logic       park_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [PRE_W-1:0] reload;

  assign reload = clocks_m1(mult_code_i);
  assign tick_o = (pre_q == '0);

  always_comb begin
    pre_nxt = pre_q;
    if (restart_i)        pre_nxt = reload;
    else if (!tick_o)     pre_nxt = pre_q - 1'b1;
    else if (!park_i)     pre_nxt = reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nxt;
  end
endmodule

// File: rtl/bbus_phase_fsm.sv
module bbus_phase_fsm
  import bbus_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             en_i,
  input  logic             wait_mode_i,
  input  logic             iordy_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] oe_len_i,
  input  logic [CNT_W-1:0] we_len_i,
  input  logic [CNT_W-1:0] rd_hold_i,
  input  logic [CNT_W-1:0] wr_hold_i,
  input  logic [CNT_W-1:0] pause_i,
  input  logic             tick_i,
  output logic             restart_o,
  output logic             park_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ack_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o
);
  phase_e           state_q, state_nxt;
  logic [CNT_W-1:0] tcnt_q, tcnt_nxt;
  logic             wr_q, wr_nxt;
  logic             ack_q, ack_nxt;
  logic             ce_n_q, oe_n_q, we_n_q;
  logic             done;

  assign park_o = (tcnt_q == '0);
  assign done   = tick_i && park_o;

  always_comb begin
    state_nxt = state_q;
    tcnt_nxt  = tcnt_q;
    wr_nxt    = wr_q;
    ack_nxt   = 1'b0;
    restart_o = 1'b0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    if (tick_i && !park_o) tcnt_nxt = tcnt_q - 1'b1;
    unique case (state_q)
      PH_IDLE: if (req_i && en_i) begin
        accept_o  = 1'b1;
        restart_o = 1'b1;
        wr_nxt    = wr_i;
        if (setup_i != '0) begin
          state_nxt = PH_SETUP;
          tcnt_nxt  = setup_i - 1'b1;
        end else begin
          state_nxt = PH_STROBE;
          tcnt_nxt  = wr_i ? we_len_i : oe_len_i;
        end
      end
      PH_SETUP: if (done) begin
        state_nxt = PH_STROBE;
        restart_o = 1'b1;
        tcnt_nxt  = wr_q ? we_len_i : oe_len_i;
      end
      PH_STROBE: if (done && (!wait_mode_i || iordy_i)) begin
        state_nxt = PH_HOLD;
        restart_o = 1'b1;
        capture_o = !wr_q;
        tcnt_nxt  = wr_q ? wr_hold_i : rd_hold_i;
      end
      PH_HOLD: if (done) begin
        state_nxt = PH_PAUSE;
        restart_o = 1'b1;
        tcnt_nxt  = pause_i;
      end
      PH_PAUSE: if (done) begin
        state_nxt = PH_IDLE;
        ack_nxt   = 1'b1;
      end
      default: state_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      tcnt_q  <= '0;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
    end else begin
      state_q <= state_nxt;
      tcnt_q  <= tcnt_nxt;
      wr_q    <= wr_nxt;
      ack_q   <= ack_nxt;
      ce_n_q  <= (state_nxt == PH_IDLE) || (state_nxt == PH_PAUSE);
      oe_n_q  <= !((state_nxt == PH_STROBE) && !wr_nxt);
      we_n_q  <= !((state_nxt == PH_STROBE) && wr_nxt);
    end
  end

  assign ack_o  = ack_q;
  assign ce_n_o = ce_n_q;
  assign oe_n_o = oe_n_q;
  assign we_n_o = we_n_q;

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_q && !we_n_q));
  a_r10_strobe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_q || !we_n_q) |-> !ce_n_q);
  a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  a_r7_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_STROBE && wait_mode_i && !iordy_i) |=> (state_q == PH_STROBE));
  a_r8_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE && req_i && !en_i) |=> (ce_n_q && state_q == PH_IDLE));
  a_r4_ce_rises_into_pause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n_q) |-> (state_q == PH_PAUSE));
endmodule

// File: rtl/bbus_region_seq.sv
module bbus_region_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              region_en_i,
  input  logic [1:0]        mult_code_i,
  input  logic              wait_mode_i,
  input  logic [CNT_W-1:0]  setup_i,
  input  logic [CNT_W-1:0]  oe_len_i,
  input  logic [CNT_W-1:0]  we_len_i,
  input  logic [CNT_W-1:0]  rd_hold_i,
  input  logic [CNT_W-1:0]  wr_hold_i,
  input  logic [CNT_W-1:0]  pause_i,
  output logic              bus_ce_n_o,
  output logic              bus_oe_n_o,
  output logic              bus_we_n_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_iordy_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              tick, restart, park, accept, capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bbus_tick_div u_tick (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mult_code_i(mult_code_i),
    .restart_i  (restart),
    .park_i     (park),
    .tick_o     (tick)
  );

  bbus_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .en_i       (region_en_i),
    .wait_mode_i(wait_mode_i),
    .iordy_i    (bus_iordy_i),
    .setup_i    (setup_i),
    .oe_len_i   (oe_len_i),
    .we_len_i   (we_len_i),
    .rd_hold_i  (rd_hold_i),
    .wr_hold_i  (wr_hold_i),
    .pause_i    (pause_i),
    .tick_i     (tick),
    .restart_o  (restart),
    .park_o     (park),
    .accept_o   (accept),
    .capture_o  (capture),
    .ack_o      (ack_o),
    .ce_n_o     (bus_ce_n_o),
    .oe_n_o     (bus_oe_n_o),
    .we_n_o     (bus_we_n_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture) rdata_q <= bus_rdata_i;
    end
  end

  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rdata_o     = rdata_q;

  a_r9_addr_stable_in_access: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_ce_n_o && $past(!bus_ce_n_o)) |-> $stable(bus_addr_o));
  a_r6_rdata_only_at_oe_rise: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(rdata_o) |-> $rose(bus_oe_n_o));
endmodule

// File: tb/bbus_region_seq_tb_top.sv
module bbus_region_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, CW = 6;

  logic          clk = 1'b0;
  logic          rst_n, req, wr, ack, en, wmode, iordy;
  logic [AW-1:0] addr, bus_addr;
  logic [DW-1:0] wdata, rdata, bus_wdata, bus_rdata;
  logic [1:0]    mcode;
  logic [CW-1:0] c_setup, c_oe, c_we, c_rh, c_wh, c_pause;
  logic          ce_n, oe_n, we_n;

  int checks = 0, errors = 0;
  int m_setup, m_strobe, m_hold, m_pause, m_oe, m_we, m_both, m_dbad, m_abad;
  int m_timeout;
  logic [DW-1:0] exp_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  bbus_region_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .region_en_i(en),
    .mult_code_i(mcode), .wait_mode_i(wmode), .setup_i(c_setup),
    .oe_len_i(c_oe), .we_len_i(c_we), .rd_hold_i(c_rh), .wr_hold_i(c_wh),
    .pause_i(c_pause), .bus_ce_n_o(ce_n), .bus_oe_n_o(oe_n),
    .bus_we_n_o(we_n), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_iordy_i(iordy)
  );

  function automatic int clocks_of(input logic [1:0] code);
    case (code)
      2'd3: return 8;
      2'd0: return 4;
      2'd2: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  // one access; counts phase clocks at negedges until ack
  task automatic run_access(input logic w, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int release_at,
                            input bit poke);
    bit seen_ce = 0, seen_str = 0, poked = 0;
    m_setup = 0; m_strobe = 0; m_hold = 0; m_pause = 0; m_oe = 0; m_we = 0;
    m_both = 0; m_dbad = 0; m_abad = 0; m_timeout = 0;
    @(negedge clk); req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk); req = 0;
    for (int i = 0; i < 5000; i++) begin
      if (poked) req = 0;
      if (ack) break;
      if (!ce_n) begin
        if (!oe_n || !we_n) begin seen_str = 1; m_strobe++; end
        else if (!seen_str) m_setup++;
        else m_hold++;
        if (bus_addr != a) m_abad++;
      end else if (seen_ce) m_pause++;
      seen_ce |= !ce_n;
      if (!oe_n && !we_n) m_both++;
      if (!oe_n) begin
        m_oe++;
        bus_rdata = bus_rdata * 16'd13 + 16'h2B1;
        exp_rd = bus_rdata;
      end
      if (!we_n) begin m_we++; if (bus_wdata != d) m_dbad++; end
      if (release_at > 0 && m_oe == release_at) iordy = 1;
      if (poke && m_strobe == 1 && !poked) begin
        req = 1; wr = ~w; addr = ~a; wdata = ~d; poked = 1;
      end
      @(negedge clk);
      if (i == 4999) m_timeout = 1;
    end
    req = 0;
    check(m_timeout == 0, "R5 ack seen", m_timeout, 0);
    @(negedge clk);
    check(ack == 1'b0, "R5 ack single clock", ack, 0);
  endtask

  task automatic set_cfg(input logic [1:0] mc, input int s, input int o,
                         input int w, input int rh, input int wh, input int p);
    mcode = mc; c_setup = CW'(s); c_oe = CW'(o); c_we = CW'(w);
    c_rh = CW'(rh); c_wh = CW'(wh); c_pause = CW'(p);
  endtask

  task automatic test_reset;
    check(ce_n && oe_n && we_n, "R11 strobes high after reset", {ce_n, oe_n, we_n}, 7);
    check(ack == 1'b0, "R11 ack low after reset", ack, 0);
  endtask

  task automatic test_read_mults;
    for (int c = 0; c < 4; c++) begin
      int m;
      set_cfg(2'(c), 2, 3, 1, 1, 4, 2);
      m = clocks_of(2'(c));
      run_access(1'b0, 16'h1230 + 16'(c), 16'h0, 0, 0);
      check(m_strobe == 4*m, "R1 R3 read strobe length", m_strobe, 4*m);
      check(m_setup == 2*m, "R2 setup length", m_setup, 2*m);
      check(m_hold == 2*m, "R4 read hold length", m_hold, 2*m);
      check(m_pause == 3*m, "R5 pause length", m_pause, 3*m);
      check(rdata == exp_rd, "R6 read data capture", rdata, exp_rd);
      check(m_we == 0 && m_abad == 0, "R10 read: no WE, stable address", m_we + m_abad, 0);
    end
  endtask

  task automatic test_write;
    set_cfg(2'd2, 1, 0, 5, 0, 3, 1);
    run_access(1'b1, 16'hBEEF, 16'hA55A, 0, 0);
    check(m_we == 12, "R3 write strobe uses WE field", m_we, 12);
    check(m_oe == 0, "R10 write never drives OE", m_oe, 0);
    check(m_hold == 8, "R4 write hold uses write field", m_hold, 8);
    check(m_setup == 2, "R2 write setup", m_setup, 2);
    check(m_pause == 4, "R5 write pause", m_pause, 4);
    check(m_dbad == 0 && m_both == 0, "R10 write data on bus", m_dbad + m_both, 0);
    check(rdata == exp_rd, "R6 read data held across write", rdata, exp_rd);
  endtask

  task automatic test_zero_setup;
    set_cfg(2'd1, 0, 0, 0, 0, 0, 0);
    run_access(1'b0, 16'h0042, 16'h0, 0, 0);
    check(m_setup == 0, "R2 zero setup: CE and OE fall together", m_setup, 0);
    check(m_strobe == 1 && m_hold == 1 && m_pause == 1, "R3 R4 minimum phases",
          m_strobe*100 + m_hold*10 + m_pause, 111);
  endtask

  task automatic test_wait_mode;
    set_cfg(2'd2, 1, 1, 1, 1, 1, 1);
    wmode = 1; iordy = 0;
    run_access(1'b0, 16'h0777, 16'h0, 9, 0);
    check(m_oe == 9, "R7 IORDY low stretches strobe", m_oe, 9);
    check(rdata == exp_rd, "R7 R6 data at stretched strobe end", rdata, exp_rd);
    wmode = 0; iordy = 0;
    run_access(1'b0, 16'h0778, 16'h0, 0, 0);
    check(m_oe == 4, "R7 IORDY ignored when wait mode off", m_oe, 4);
    iordy = 1;
  endtask

  task automatic test_disabled;
    int ce_low = 0, acks = 0;
    set_cfg(2'd1, 1, 1, 1, 1, 1, 1);
    en = 0;
    @(negedge clk); req = 1; wr = 0;
    @(negedge clk); req = 0;
    for (int i = 0; i < 30; i++) begin
      if (!ce_n || !oe_n || !we_n) ce_low++;
      if (ack) acks++;
      @(negedge clk);
    end
    check(ce_low == 0, "R8 disabled region keeps strobes high", ce_low, 0);
    check(acks == 0, "R8 disabled region gives no ack", acks, 0);
    en = 1;
  endtask

  task automatic test_busy;
    int extra = 0;
    set_cfg(2'd0, 1, 2, 2, 1, 1, 1);
    run_access(1'b0, 16'h0C0C, 16'h1111, 0, 1);
    check(m_oe == 12 && m_we == 0, "R9 busy request leaves read timing", m_oe, 12);
    check(m_abad == 0, "R9 busy request leaves address", m_abad, 0);
    for (int i = 0; i < 40; i++) begin
      if (!ce_n || ack) extra++;
      @(negedge clk);
    end
    check(extra == 0, "R9 no second access or ack", extra, 0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; req = 0; wr = 0; addr = '0; wdata = '0; en = 1; wmode = 0;
    iordy = 1; bus_rdata = 16'h5A5A; exp_rd = '0;
    set_cfg(2'd1, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    test_reset;
    test_read_mults;
    test_write;
    test_zero_setup;
    test_wait_mode;
    test_disabled;
    test_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule